// File: doc/BRIEF.md
# Supply Fault Output Controller

This block is the digital core of a single-rail supply supervisor. Two comparator results arrive from outside: one says the monitored rail is below its low trip point, the other says it is above its high trip point. Four more control levels arrive with them. One flags that the supervisor's own supply is not yet valid (lockout). One selects between latched and self-clearing overvoltage reporting. One masks both fault outputs. One strap removes the release delay. All six inputs are asynchronous and pass through synchronizer stages first.

The block drives an active-low undervoltage output and an overvoltage output whose active level is chosen by a parameter. Each output asserts while its fault is present. After the fault goes away, the output stays asserted for a release delay of `HOLD_CYCLES` clock cycles. The two outputs time their delays independently. A fault that returns during the delay cancels it, and the delay starts again from zero once the fault clears. Overvoltage can be made sticky until software or a board strap raises the latch control. Both outputs come straight from flops.

Latency (default two synchronizer stages, inputs driven between clock edges): an output driven by a rail fault changes on the 4th rising edge after the raw input changes. Lockout and the output mask act on the 3rd edge. A release that waits out the delay happens on edge `HOLD_CYCLES + 4`.

Top module: `uvov_fault_ctrl`

## Requirements
- R1: A raw undervoltage flag rising drives `uv_n` low on the 4th clock edge. A raw overvoltage flag rising drives the overvoltage output to its active level on the 4th clock edge, unless lockout or the mask is active.
- R2: After the raw undervoltage flag falls, `uv_n` stays low through edge `HOLD_CYCLES + 3` and goes high on edge `HOLD_CYCLES + 4`.
- R3: If the undervoltage flag returns while the release delay is running, the delay is cancelled. `uv_n` then goes high `HOLD_CYCLES + 4` edges after the flag falls again.
- R4: With the latch control low (0 = latched mode), an overvoltage event keeps the output active after the flag clears, for any length of time. Raising the latch control to 1 starts the release delay, and the output goes inactive on edge `HOLD_CYCLES + 4` after that rise.
- R5: With the latch control at 1, overvoltage follows the same assert and delayed-release timing as undervoltage. If the latch control drops to 0 while that delay is running, the output stays active as in latched mode.
- R6: While lockout is 1, `uv_n` is low from the 3rd edge and the overvoltage output is inactive whatever the overvoltage flag does. When lockout falls, `uv_n` goes high on edge `HOLD_CYCLES + 4`.
- R7: While the mask input is 1, both outputs are inactive whatever the rail faults do. If lockout rises while masked, `uv_n` still goes low on the 3rd edge. When lockout then falls, `uv_n` goes high on the 3rd edge with no delay.
- R8: While the bypass strap is 1, each output releases on the 4th edge after its fault flag falls.
- R9: The two release delays run independently. Faults that clear two cycles apart release their outputs two cycles apart.
- R10: During and after reset the block behaves as if lockout had just been active. `uv_n` is low and the overvoltage output is inactive. `uv_n` goes high on edge `HOLD_CYCLES + 4` after reset is released, provided no fault is present.
- R11: With `OV_ACTIVE_HIGH` = 1 the overvoltage output is 1 when active. With `OV_ACTIVE_HIGH` = 0 it is 0 when active. This setting changes no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| under_async | input | 1 | Rail below low trip point (raw comparator level) |
| over_async | input | 1 | Rail above high trip point (raw comparator level) |
| lockout_async | input | 1 | Supervisor supply invalid |
| latch_ctl_async | input | 1 | 0: overvoltage latches; 1: clears the latch and makes overvoltage self-clearing |
| quiet_async | input | 1 | 1: mask both fault outputs (lockout still asserts `uv_n`) |
| hold_bypass_async | input | 1 | 1: release delay is zero |
| uv_n | output | 1 | Undervoltage output, active low |
| ov_out | output | 1 | Overvoltage output, active level set by `OV_ACTIVE_HIGH` |

## Verification
The bench builds two copies side by side from the same inputs: one with `OV_ACTIVE_HIGH` = 0 and one with `OV_ACTIVE_HIGH` = 1. This lets the polarity option be compared edge for edge. Both copies use `HOLD_CYCLES` = 6. That is short enough to step exactly to the edge before and the edge of every release. It also allows a fault to be re-injected partway through a delay, and lets the two channels' delays overlap by a known offset within a few dozen cycles.

// File: rtl/uvov_pkg.sv
package uvov_pkg;

    // Synchronized control and fault levels, one bit each
    typedef struct packed {
        logic under;
        logic over;
        logic lockout;
        logic latch_ctl;
        logic quiet;
        logic hold_bypass;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    // Reset state looks like supervisor-supply lockout, latched OV mode
    localparam flags_t FLAGS_RST = '{under: 1'b0, over: 1'b0, lockout: 1'b1,
                                     latch_ctl: 1'b0, quiet: 1'b0, hold_bypass: 1'b0};

    // Registered output state
    typedef struct packed {
        logic uv_n;
        logic ov_assert;
    } outs_t;

endpackage

// File: rtl/uvov_sync.sv
module uvov_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/uvov_hold_chan.sv
module uvov_hold_chan #(
    parameter int HOLD_CYCLES = 1000,
    parameter bit RST_ACTIVE  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,    // fault present this cycle
    input  logic freeze,   // keep an active channel active, delay held at zero
    input  logic flush,    // force inactive
    input  logic bypass,   // zero-length delay
    output logic active
);

    localparam int               CNT_W    = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (fault) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (freeze) begin
                st_d.cnt = '0;
            end else if (bypass || (st_q.cnt == CNT_LAST)) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= RST_ACTIVE;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;

    AST_FAULT_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !flush) |=> active);  // R1

    AST_RELEASE_AFTER_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active) && !$past(flush) && !$past(bypass)) |-> ($past(st_q.cnt) == CNT_LAST));  // R2

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);  // R3

    AST_FREEZE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && freeze && !flush) |=> active);  // R4

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !active);  // R6

endmodule

// File: rtl/uvov_fault_ctrl.sv
module uvov_fault_ctrl #(
    parameter int HOLD_CYCLES    = 1000,
    parameter int SYNC_STAGES    = 2,
    parameter bit OV_ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic under_async,
    input  logic over_async,
    input  logic lockout_async,
    input  logic latch_ctl_async,
    input  logic quiet_async,
    input  logic hold_bypass_async,
    output logic uv_n,
    output logic ov_out
);
    import uvov_pkg::*;

    flags_t raw_d;
    flags_t flg;
    logic   uv_active;
    logic   ov_active;
    outs_t  out_d, out_q;

    assign raw_d = '{under: under_async, over: over_async, lockout: lockout_async,
                     latch_ctl: latch_ctl_async, quiet: quiet_async,
                     hold_bypass: hold_bypass_async};

    uvov_sync #(
        .WIDTH  (FLAG_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(FLAGS_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_d),
        .q    (flg)
    );

    // Undervoltage: lockout counts as a fault so its end runs the delay
    uvov_hold_chan #(
        .HOLD_CYCLES(HOLD_CYCLES),
        .RST_ACTIVE (1'b1)
    ) u_uv_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .fault (flg.under | flg.lockout),
        .freeze(1'b0),
        .flush (1'b0),
        .bypass(flg.hold_bypass),
        .active(uv_active)
    );

    // Overvoltage: latched while latch control is low, wiped by lockout
    uvov_hold_chan #(
        .HOLD_CYCLES(HOLD_CYCLES),
        .RST_ACTIVE (1'b0)
    ) u_ov_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .fault (flg.over & ~flg.lockout),
        .freeze(~flg.latch_ctl),
        .flush (flg.lockout),
        .bypass(flg.hold_bypass),
        .active(ov_active)
    );

    always_comb begin
        out_d.uv_n      = ~(flg.lockout | (uv_active & ~flg.quiet));
        out_d.ov_assert = ov_active & ~flg.quiet & ~flg.lockout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{uv_n: 1'b0, ov_assert: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign uv_n = out_q.uv_n;

    generate
        if (OV_ACTIVE_HIGH) begin : g_ov_high
            assign ov_out = out_q.ov_assert;
        end else begin : g_ov_low
            assign ov_out = ~out_q.ov_assert;
        end
    endgenerate

    AST_LOCKOUT_FORCES_UV: assert property (@(posedge clk) disable iff (!rst_n)
        flg.lockout |=> !uv_n);  // R6

    AST_LOCKOUT_BLOCKS_OV: assert property (@(posedge clk) disable iff (!rst_n)
        flg.lockout |=> !out_q.ov_assert);  // R6

    AST_QUIET_BLOCKS_OV: assert property (@(posedge clk) disable iff (!rst_n)
        flg.quiet |=> !out_q.ov_assert);  // R7

    AST_QUIET_RELEASES_UV: assert property (@(posedge clk) disable iff (!rst_n)
        (flg.quiet && !flg.lockout) |=> uv_n);  // R7

    AST_OV_LEVEL_MAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ov_out == (OV_ACTIVE_HIGH ? out_q.ov_assert : ~out_q.ov_assert));  // R11

endmodule

// File: tb/uvov_fault_ctrl_tb_top.sv
module uvov_fault_ctrl_tb_top;

    localparam int H = 6;
    localparam int SETTLE = 16;
    localparam int NVEC = 14;

    // {under, over, lockout, latch_ctl, quiet, bypass, exp_uv_n, exp_ov_n}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b000100_11,  // idle, self-clearing OV
        8'b100100_01,  // undervoltage
        8'b000100_11,
        8'b010100_10,  // overvoltage, self-clearing
        8'b000100_11,
        8'b010000_10,  // overvoltage, latched mode
        8'b000000_10,  // latch holds
        8'b000100_11,  // latch cleared
        8'b110110_11,  // mask hides both
        8'b001110_01,  // lockout under mask
        8'b011100_01,  // lockout blocks OV
        8'b000100_11,
        8'b110101_00,  // bypass strap
        8'b000101_11
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic under = 1'b0, over = 1'b0, lock = 1'b0, clr = 1'b1, dis = 1'b0, byp = 1'b0;
    logic uv_n, ov_n, uv_n_hi, ov_hi;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    uvov_fault_ctrl #(.HOLD_CYCLES(H), .OV_ACTIVE_HIGH(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .under_async(under), .over_async(over),
        .lockout_async(lock), .latch_ctl_async(clr), .quiet_async(dis),
        .hold_bypass_async(byp), .uv_n(uv_n), .ov_out(ov_n));

    uvov_fault_ctrl #(.HOLD_CYCLES(H), .OV_ACTIVE_HIGH(1'b1)) dut_hi_i (
        .clk(clk), .rst_n(rst_n), .under_async(under), .over_async(over),
        .lockout_async(lock), .latch_ctl_async(clr), .quiet_async(dis),
        .hold_bypass_async(byp), .uv_n(uv_n_hi), .ov_out(ov_hi));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_pol(input string what);
        chk("R11", what, ov_hi, ~ov_n);
        chk("R11", {what, " uv match"}, uv_n_hi, uv_n);
    endtask

    task automatic apply(input logic [5:0] v);
        @(negedge clk);
        {under, over, lock, clr, dis, byp} = v;
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R10";
            1:       return "R1";
            2:       return "R2";
            3, 4:    return "R5";
            5, 6, 7: return "R4";
            8, 9:    return "R7";
            10, 11:  return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        // R10: reset state and release sequence
        #10;
        chk("R10", "uv during reset", uv_n, 1'b0);
        chk("R10", "ov during reset", ov_n, 1'b1);
        chk_pol("reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(H + 3);
        chk("R10", "uv before release", uv_n, 1'b0);
        step(1);
        chk("R10", "uv released", uv_n, 1'b1);

        // Steady-state table
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][7:2]);
            step(SETTLE);
            chk(vec_tag(i), $sformatf("vec %0d uv", i), uv_n, VEC[i][1]);
            chk(vec_tag(i), $sformatf("vec %0d ov", i), ov_n, VEC[i][0]);
            chk_pol($sformatf("vec %0d", i));
        end
        apply(6'b000100);
        step(SETTLE);

        // R1 / R2: assert latency and full release delay
        apply(6'b100100);
        step(3);
        chk("R1", "uv before assert", uv_n, 1'b1);
        step(1);
        chk("R1", "uv asserted", uv_n, 1'b0);
        apply(6'b000100);
        step(H + 3);
        chk("R2", "uv held", uv_n, 1'b0);
        step(1);
        chk("R2", "uv released", uv_n, 1'b1);

        // R3: re-fault during delay restarts it
        apply(6'b100100);
        step(SETTLE);
        apply(6'b000100);
        step(3);
        apply(6'b100100);
        apply(6'b000100);
        step(H + 3);
        chk("R3", "uv held after restart", uv_n, 1'b0);
        step(1);
        chk("R3", "uv released after restart", uv_n, 1'b1);

        // R4: latched overvoltage and clear timing
        apply(6'b010000);
        step(3);
        chk("R4", "ov before assert", ov_n, 1'b1);
        step(1);
        chk("R4", "ov asserted", ov_n, 1'b0);
        apply(6'b000000);
        step(5 * H);
        chk("R4", "ov latched", ov_n, 1'b0);
        apply(6'b000100);
        step(H + 3);
        chk("R4", "ov held after clear", ov_n, 1'b0);
        step(1);
        chk("R4", "ov released after clear", ov_n, 1'b1);

        // R5: self-clearing OV, then latch entered mid-delay
        apply(6'b010100);
        step(SETTLE);
        apply(6'b000100);
        step(H + 3);
        chk("R5", "ov held", ov_n, 1'b0);
        step(1);
        chk("R5", "ov released", ov_n, 1'b1);
        apply(6'b010100);
        step(SETTLE);
        apply(6'b000100);
        step(2);
        apply(6'b000000);
        step(3 * H);
        chk("R5", "ov latched mid-delay", ov_n, 1'b0);
        apply(6'b000100);
        step(H + 4);
        chk("R5", "ov released after clear", ov_n, 1'b1);

        // R9: independent delays offset by two cycles
        apply(6'b110100);
        step(SETTLE);
        apply(6'b010100);
        step(2);
        apply(6'b000100);
        step(H + 1);
        chk("R9", "uv held", uv_n, 1'b0);
        step(1);
        chk("R9", "uv released", uv_n, 1'b1);
        chk("R9", "ov still held", ov_n, 1'b0);
        step(1);
        chk("R9", "ov held one more", ov_n, 1'b0);
        step(1);
        chk("R9", "ov released", ov_n, 1'b1);

        // R6: lockout latency and delayed release
        apply(6'b011100);
        step(2);
        chk("R6", "uv before lockout", uv_n, 1'b1);
        step(1);
        chk("R6", "uv forced", uv_n, 1'b0);
        step(SETTLE);
        chk("R6", "ov blocked", ov_n, 1'b1);
        apply(6'b000100);
        step(H + 3);
        chk("R6", "uv held after lockout", uv_n, 1'b0);
        step(1);
        chk("R6", "uv released after lockout", uv_n, 1'b1);

        // R7: mask with lockout, no delay on release
        apply(6'b110110);
        step(SETTLE);
        chk("R7", "uv masked", uv_n, 1'b1);
        chk("R7", "ov masked", ov_n, 1'b1);
        apply(6'b001110);
        step(2);
        chk("R7", "uv before lockout", uv_n, 1'b1);
        step(1);
        chk("R7", "uv lockout under mask", uv_n, 1'b0);
        apply(6'b000110);
        step(2);
        chk("R7", "uv before quick release", uv_n, 1'b0);
        step(1);
        chk("R7", "uv quick release", uv_n, 1'b1);
        apply(6'b000100);
        step(SETTLE);

        // R8: bypass strap
        apply(6'b000101);
        step(4);
        apply(6'b110101);
        step(SETTLE);
        apply(6'b000101);
        step(3);
        chk("R8", "uv before release", uv_n, 1'b0);
        chk("R8", "ov before release", ov_n, 1'b0);
        step(1);
        chk("R8", "uv released", uv_n, 1'b1);
        chk("R8", "ov released", ov_n, 1'b1);
        chk_pol("bypass end");

        done = 1'b1;
        report();
        $finish;
    end

endmodule